// File: doc/BRIEF.md
# Bandwidth-Throttled Timed Memory Responder

This block is a memory target that stands at the far end of a request/response fabric. Requests arrive on a valid/ready port carrying a command, a word address, write data, a transfer size in bytes, a flag saying whether an answer is expected, and two transfer-delay fields. Reads return a word from a 256-entry, 32-bit storage array. Writes update that array at the moment of acceptance. Every answer waits in a response buffer until its own release cycle. That cycle is the acceptance cycle plus the two transfer delays, a base latency, and a pseudo-random jitter bounded by a programmable variance.

Short-term bandwidth is limited by a busy window. Each accepted legal request holds the block busy for its size multiplied by a per-byte cost, and a request offered during that window is refused. The block remembers that it owes the refused requester a retry. It signals that retry with a one-cycle strobe once it can accept again. The response buffer is a separate block that keeps entries in release-time order. A new entry never passes an older entry to the same address and never goes ahead of the current head. An idle output lets a controller confirm that the block has drained.

Top module: `timed_mem_responder`

## Requirements
- R1: Command code 2'b01 is a read and 2'b10 is a write. Codes 2'b00 and 2'b11 are still handshaken. They raise `cmdErr` for exactly the cycle after acceptance, and they change no storage, create no response and start no busy window.
- R2: After accepting a legal request, `busy` is high for exactly reqSize × cost cycles, starting the cycle after acceptance. If the product is zero, `busy` never rises.
- R3: `reqReady` is low while `busy` is high or while the response buffer holds BUF_DEPTH entries. A request offered while `reqReady` is low is refused and records an owed retry.
- R4: `retryStrobe` is high, for one cycle only, in the first cycle in which a retry is owed and `reqReady` is high. The owed retry is then cleared.
- R5: A response accepted in cycle T has release cycle T + hdrDelay + payDelay + latency + jitter, where cycle numbers count from 0 at the first cycle after reset. The buffer head is presented on `respValid` once its release cycle is less than or equal to the current cycle, and is removed when `respReady` is high.
- R6: A write updates storage at acceptance. A read returns the word held at acceptance, including the effect of any earlier accepted write. A write that asks for a response returns the written word.
- R7: A request with `reqNeedsResp` low produces no buffer entry.
- R8: Jitter is L mod (variance + 1), where L is the value of a 16-bit LFSR taken before it steps. The LFSR is seeded to 16'hACE1 at reset and steps once per handshaken request as L ← {L[14:0], L[15]^L[13]^L[12]^L[10]}. Jitter is zero when the variance is zero.
- R9: An entry is inserted directly after the youngest entry it may not pass. It may pass only an entry with a strictly later release cycle and a different address. It is never placed ahead of the head, so the head entry holds steady while it waits on `respReady`.
- R10: `idle` is high exactly when `busy` is low and the response buffer is empty.
- R11: Latency, variance and per-byte cost are captured on each clock edge while `rstN` is low. After reset is released, changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; configuration is captured while low |
| cfgLatency | input | LAT_W | Base response latency in cycles |
| cfgVariance | input | VAR_W | Upper bound of the random extra delay |
| cfgByteCost | input | COST_W | Busy cycles charged per request byte |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqCmd | input | 2 | Command code (01 read, 10 write) |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqSize | input | SIZE_W | Transfer size in bytes |
| reqNeedsResp | input | 1 | A response is expected |
| reqHdrDelay | input | DLY_W | Header transfer delay in cycles |
| reqPayDelay | input | DLY_W | Payload transfer delay in cycles |
| respValid | output | 1 | Head response has reached its release cycle |
| respReady | input | 1 | Requester takes the response |
| respAddr | output | ADDR_W | Address of the head response |
| respData | output | DATA_W | Data of the head response |
| retryStrobe | output | 1 | One-cycle invitation to resend a refused request |
| cmdErr | output | 1 | One-cycle flag for an illegal command |
| busy | output | 1 | Bandwidth window in progress |
| idle | output | 1 | Not busy and response buffer empty |

## Verification
The bench builds the block with BUF_DEPTH of 4 and the default 8-bit address and 32-bit data. The shallow buffer makes the full-buffer refusal path easy to reach once `respReady` is held low. Traffic is confined mostly to eight addresses, so insertions regularly meet an older entry to the same address and must stop behind it. The bench runs three configurations. A latency of 3 with variance 5 and cost 2 exercises jitter and reordering. An all-zero configuration reaches the zero-jitter and never-busy paths. A latency of 20 with variance 15 and cost 3 holds long busy windows and keeps the buffer full.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_WRITE = 2'b10;

  // strobes raised by the control for the datapath in the accepting cycle
  typedef struct packed {
    logic doWrite;     // store reqWdata at reqAddr
    logic pushResp;    // place a response in the time-ordered buffer
    logic advanceRng;  // step the jitter generator
  } tmrStrobes_t;

  function automatic logic cmdIsLegal(input logic [1:0] cmd);
    return (cmd == CMD_READ) || (cmd == CMD_WRITE);
  endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SIZE_W = 4,
  parameter int COST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COST_W-1:0] cfgByteCost,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqNeedsResp,
  input  logic              bufFull,
  output logic              reqReady,
  output logic              busy,
  output logic              retryStrobe,
  output logic              cmdErr,
  output tmrStrobes_t       strb
);

  localparam int BUSY_W = SIZE_W + COST_W;

  logic [COST_W-1:0] costReg;
  logic [BUSY_W-1:0] busyCnt;
  logic [BUSY_W-1:0] windowLen;
  logic              retryOwed;
  logic              fire;
  logic              legal;
  logic              acceptLegal;

  always_comb begin
    busy        = (busyCnt != '0);
    reqReady    = !busy && !bufFull;
    fire        = reqValid && reqReady;
    legal       = cmdIsLegal(reqCmd);
    acceptLegal = fire && legal;
    windowLen   = BUSY_W'(reqSize) * BUSY_W'(costReg);
    retryStrobe = retryOwed && reqReady;
    strb.doWrite    = fire && (reqCmd == CMD_WRITE);
    strb.pushResp   = acceptLegal && reqNeedsResp;
    strb.advanceRng = fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      costReg   <= cfgByteCost;
      busyCnt   <= '0;
      retryOwed <= 1'b0;
      cmdErr    <= 1'b0;
    end else begin
      cmdErr <= fire && !legal;
      if (acceptLegal) begin
        busyCnt <= windowLen;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (retryStrobe) begin
        retryOwed <= 1'b0;
      end else if (reqValid && !reqReady) begin
        retryOwed <= 1'b1;
      end
    end
  end

  // R2
  busy_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && legal && reqSize != '0 && costReg != '0) |=> busy);

  // R2
  zero_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && legal && (reqSize == '0 || costReg == '0)) |=> !busy);

  // R4
  retry_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryStrobe |=> !retryStrobe);

  // R1
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> $past(reqValid && reqReady && !cmdIsLegal(reqCmd)));

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 8,
  parameter int VAR_W  = 8,
  parameter int DLY_W  = 4,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic [VAR_W-1:0]  cfgVariance,
  input  tmrStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DLY_W-1:0]  reqHdrDelay,
  input  logic [DLY_W-1:0]  reqPayDelay,
  output logic [TIME_W-1:0] nowCnt,
  output logic              pushEn,
  output logic [TIME_W-1:0] pushTime,
  output logic [DATA_W-1:0] pushData
);

  localparam int WORDS   = 1 << ADDR_W;
  localparam int RNG_W   = 16;
  localparam int VAR1_W  = VAR_W + 1;
  localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

  logic [DATA_W-1:0] mem [WORDS];
  logic [LAT_W-1:0]  latReg;
  logic [VAR_W-1:0]  varReg;
  logic [RNG_W-1:0]  lfsr;
  logic              lfsrFb;
  logic [VAR1_W-1:0] modBase;
  logic [RNG_W-1:0]  jitter;

  always_comb begin
    lfsrFb  = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
    modBase = {1'b0, varReg} + 1'b1;
    if (varReg == '0) begin
      jitter = '0;
    end else begin
      jitter = lfsr % RNG_W'(modBase);
    end
    pushEn   = strb.pushResp;
    pushTime = nowCnt + TIME_W'(reqHdrDelay) + TIME_W'(reqPayDelay)
             + TIME_W'(latReg) + TIME_W'(jitter);
    pushData = strb.doWrite ? reqWdata : mem[reqAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg <= cfgLatency;
      varReg <= cfgVariance;
      nowCnt <= '0;
      lfsr   <= RNG_SEED;
    end else begin
      nowCnt <= nowCnt + 1'b1;
      if (strb.advanceRng) begin
        lfsr <= {lfsr[RNG_W-2:0], lfsrFb};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) begin
        mem[w] <= '0;
      end
    end else if (strb.doWrite) begin
      mem[reqAddr] <= reqWdata;
    end
  end

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |=> (mem[$past(reqAddr)] == $past(reqWdata)));

  // R8
  jitter_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    jitter <= RNG_W'(varReg));

endmodule

// File: rtl/tmr_resp_buf.sv
module tmr_resp_buf #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] nowCnt,
  input  logic              pushEn,
  input  logic [TIME_W-1:0] pushTime,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReady,
  output logic              headValid,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              full,
  output logic              empty
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = TIME_W + ADDR_W + DATA_W;

  logic [ENT_W-1:0]  slot     [DEPTH];
  logic [ENT_W-1:0]  staged   [DEPTH];
  logic [ENT_W-1:0]  slotNext [DEPTH];
  logic [TIME_W-1:0] slotTime [DEPTH];
  logic [ADDR_W-1:0] slotAddr [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  insPos;
  logic [ENT_W-1:0]  newEnt;
  logic              pop;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      slotTime[j] = slot[j][ENT_W-1 -: TIME_W];
      slotAddr[j] = slot[j][DATA_W +: ADDR_W];
    end
    empty     = (count == '0);
    full      = (count == CNT_W'(DEPTH));
    headValid = !empty && !(nowCnt < slotTime[0]);
    headAddr  = slotAddr[0];
    headData  = slot[0][DATA_W-1:0];
    pop       = headValid && popReady;
    newEnt    = {pushTime, pushAddr, pushData};
  end

  // insertion point: behind the youngest entry the new one may not pass,
  // and never ahead of the head
  always_comb begin
    insPos = empty ? '0 : CNT_W'(1);
    for (int j = 1; j < DEPTH; j++) begin
      if (CNT_W'(j) < count &&
          (!(pushTime < slotTime[j]) || slotAddr[j] == pushAddr)) begin
        insPos = CNT_W'(j + 1);
      end
    end
  end

  always_comb begin
    staged[0] = (pushEn && insPos == '0) ? newEnt : slot[0];
    for (int k = 1; k < DEPTH; k++) begin
      if (pushEn && CNT_W'(k) == insPos) begin
        staged[k] = newEnt;
      end else if (pushEn && CNT_W'(k) > insPos) begin
        staged[k] = slot[k-1];
      end else begin
        staged[k] = slot[k];
      end
    end
    for (int k = 0; k < DEPTH - 1; k++) begin
      slotNext[k] = pop ? staged[k+1] : staged[k];
    end
    slotNext[DEPTH-1] = pop ? '0 : staged[DEPTH-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        slot[k] <= '0;
      end
    end else begin
      count <= count + CNT_W'(pushEn) - CNT_W'(pop);
      for (int k = 0; k < DEPTH; k++) begin
        slot[k] <= slotNext[k];
      end
    end
  end

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !popReady) |=> (headValid && slot[0] == $past(slot[0])));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R3
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> !full);

endmodule

// File: rtl/timed_mem_responder.sv
module timed_mem_responder
  import tmr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int COST_W    = 4,
  parameter int LAT_W     = 8,
  parameter int VAR_W     = 8,
  parameter int DLY_W     = 4,
  parameter int TIME_W    = 32,
  parameter int BUF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic [VAR_W-1:0]  cfgVariance,
  input  logic [COST_W-1:0] cfgByteCost,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic              reqNeedsResp,
  input  logic [DLY_W-1:0]  reqHdrDelay,
  input  logic [DLY_W-1:0]  reqPayDelay,
  output logic              respValid,
  input  logic              respReady,
  output logic [ADDR_W-1:0] respAddr,
  output logic [DATA_W-1:0] respData,
  output logic              retryStrobe,
  output logic              cmdErr,
  output logic              busy,
  output logic              idle
);

  tmrStrobes_t       strb;
  logic              bufFull;
  logic              bufEmpty;
  logic [TIME_W-1:0] nowCnt;
  logic              pushEn;
  logic [TIME_W-1:0] pushTime;
  logic [DATA_W-1:0] pushData;

  tmr_ctrl #(
    .SIZE_W(SIZE_W),
    .COST_W(COST_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .cfgByteCost(cfgByteCost),
    .reqValid(reqValid),
    .reqCmd(reqCmd),
    .reqSize(reqSize),
    .reqNeedsResp(reqNeedsResp),
    .bufFull(bufFull),
    .reqReady(reqReady),
    .busy(busy),
    .retryStrobe(retryStrobe),
    .cmdErr(cmdErr),
    .strb(strb)
  );

  tmr_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LAT_W(LAT_W),
    .VAR_W(VAR_W),
    .DLY_W(DLY_W),
    .TIME_W(TIME_W)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .cfgLatency(cfgLatency),
    .cfgVariance(cfgVariance),
    .strb(strb),
    .reqAddr(reqAddr),
    .reqWdata(reqWdata),
    .reqHdrDelay(reqHdrDelay),
    .reqPayDelay(reqPayDelay),
    .nowCnt(nowCnt),
    .pushEn(pushEn),
    .pushTime(pushTime),
    .pushData(pushData)
  );

  tmr_resp_buf #(
    .DEPTH(BUF_DEPTH),
    .TIME_W(TIME_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uBuf (
    .clk(clk),
    .rstN(rstN),
    .nowCnt(nowCnt),
    .pushEn(pushEn),
    .pushTime(pushTime),
    .pushAddr(reqAddr),
    .pushData(pushData),
    .popReady(respReady),
    .headValid(respValid),
    .headAddr(respAddr),
    .headData(respData),
    .full(bufFull),
    .empty(bufEmpty)
  );

  assign idle = !busy && bufEmpty;

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> (!respValid && reqReady));

endmodule

// File: tb/sim_timed_mem_responder.sv
module sim_timed_mem_responder;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, DATA_W = 32, SIZE_W = 4, COST_W = 4;
  localparam int LAT_W = 8, VAR_W = 8, DLY_W = 4, TIME_W = 32, BUF_DEPTH = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              rstN;
  logic [LAT_W-1:0]  cfgLatency;
  logic [VAR_W-1:0]  cfgVariance;
  logic [COST_W-1:0] cfgByteCost;
  logic              reqValid, reqReady, reqNeedsResp;
  logic [1:0]        reqCmd;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [SIZE_W-1:0] reqSize;
  logic [DLY_W-1:0]  reqHdrDelay, reqPayDelay;
  logic              respValid, respReady;
  logic [ADDR_W-1:0] respAddr;
  logic [DATA_W-1:0] respData;
  logic              retryStrobe, cmdErr, busy, idle;

  timed_mem_responder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .COST_W(COST_W),
    .LAT_W(LAT_W), .VAR_W(VAR_W), .DLY_W(DLY_W), .TIME_W(TIME_W),
    .BUF_DEPTH(BUF_DEPTH)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgLatency(cfgLatency), .cfgVariance(cfgVariance),
    .cfgByteCost(cfgByteCost), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSize(reqSize),
    .reqNeedsResp(reqNeedsResp), .reqHdrDelay(reqHdrDelay), .reqPayDelay(reqPayDelay),
    .respValid(respValid), .respReady(respReady), .respAddr(respAddr),
    .respData(respData), .retryStrobe(retryStrobe), .cmdErr(cmdErr),
    .busy(busy), .idle(idle)
  );

  int nChecks = 0;
  int nFail = 0;
  bit checking = 0;
  int unsigned seed = 32'h1234_5678;

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int unsigned t;
    int unsigned a;
    int unsigned d;
  } ent_t;

  ent_t        mq[$];
  int unsigned mMem[256];
  int unsigned mNow;
  int unsigned mBusy;
  bit          mOwed, mErr;
  logic [15:0] mLfsr;
  int unsigned mLat, mVar, mCost;

  always @(posedge clk) begin : model
    bit ready, fire, legal, pop, retry;
    int idx;
    int unsigned jit;
    ent_t e;
    if (!rstN) begin
      mLat = cfgLatency; mVar = cfgVariance; mCost = cfgByteCost;
      mq.delete();
      foreach (mMem[i]) mMem[i] = 0;
      mNow = 0; mBusy = 0; mOwed = 0; mErr = 0; mLfsr = 16'hACE1;
    end else begin
      ready = (mBusy == 0) && (mq.size() < BUF_DEPTH);
      fire  = reqValid && ready;
      legal = (reqCmd == 2'b01) || (reqCmd == 2'b10);
      pop   = (mq.size() > 0) && (mq[0].t <= mNow) && respReady;
      retry = mOwed && ready;
      jit   = (mVar == 0) ? 0 : (int'(mLfsr) % (mVar + 1));
      if (fire && legal && reqNeedsResp) begin
        e.t = mNow + reqHdrDelay + reqPayDelay + mLat + jit;
        e.a = reqAddr;
        e.d = (reqCmd == 2'b10) ? reqWdata : mMem[reqAddr];
        idx = mq.size();
        while (idx > 1 && e.t < mq[idx-1].t && mq[idx-1].a != e.a) idx--;
        mq.insert(idx, e);
      end
      if (pop) void'(mq.pop_front());
      if (fire && reqCmd == 2'b10) mMem[reqAddr] = reqWdata;
      mErr = fire && !legal;
      if (fire && legal) mBusy = reqSize * mCost;
      else if (mBusy > 0) mBusy--;
      if (retry) mOwed = 0;
      else if (reqValid && !ready) mOwed = 1;
      if (fire) mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
      mNow++;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit mRdy, mVal;
    mRdy = (mBusy == 0) && (mq.size() < BUF_DEPTH);
    mVal = (mq.size() > 0) && (mq[0].t <= mNow);
    chk("R3", "reqReady", reqReady, mRdy);
    chk("R2", "busy", busy, mBusy != 0);
    chk("R4", "retryStrobe", retryStrobe, mOwed && mRdy);
    chk("R1", "cmdErr", cmdErr, mErr);
    chk("R5 R8", "respValid", respValid, mVal);
    if (mVal) begin
      chk("R6", "respData", respData, mq[0].d);
      chk("R9", "respAddr", respAddr, mq[0].a);
    end
    chk("R10", "idle", idle, (mBusy == 0) && (mq.size() == 0));
  endtask

  task automatic tick();
    @(negedge clk);
    if (checking) compareAll();
  endtask

  function automatic int unsigned rnd(int unsigned m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return (seed >> 16) % m;
  endfunction

  task automatic quiet();
    reqValid = 0; reqCmd = 2'b01; reqAddr = '0; reqWdata = '0; reqSize = '0;
    reqNeedsResp = 0; reqHdrDelay = '0; reqPayDelay = '0;
  endtask

  task automatic doReset(int lat, int vr, int cost);
    rstN = 0; cfgLatency = LAT_W'(lat); cfgVariance = VAR_W'(vr); cfgByteCost = COST_W'(cost);
    quiet(); respReady = 1;
    repeat (3) tick();
    checking = 1;
    // reset state
    chk("R10", "idle after reset", idle, 1);
    chk("R3", "reqReady after reset", reqReady, 1);
    chk("R5", "respValid after reset", respValid, 0);
    rstN = 1;
  endtask

  task automatic randomTraffic(int cycles, int readyPct);
    for (int c = 0; c < cycles; c++) begin
      tick();
      reqValid     = (rnd(100) < 60);
      reqCmd       = (rnd(10) == 0) ? ((rnd(2) == 0) ? 2'b00 : 2'b11)
                                    : ((rnd(2) == 0) ? 2'b01 : 2'b10);
      reqAddr      = (rnd(8) == 0) ? ADDR_W'(8'hFF) : ADDR_W'(rnd(8));
      reqWdata     = DATA_W'(rnd(32'h7FFF_FFFF)) ^ DATA_W'(c);
      reqSize      = SIZE_W'(rnd(4));
      reqNeedsResp = (rnd(4) != 0);
      reqHdrDelay  = DLY_W'(rnd(4));
      reqPayDelay  = DLY_W'(rnd(4));
      respReady    = (rnd(100) < readyPct);
    end
  endtask

  task automatic drain();
    tick(); quiet(); respReady = 1;
    repeat (90) tick();
    chk("R10", "idle after drain", idle, 1);
  endtask

  task automatic sendOne(logic [1:0] cmd, int addr, int unsigned data, int size, bit needs);
    reqValid = 1; reqCmd = cmd; reqAddr = ADDR_W'(addr); reqWdata = data;
    reqSize = SIZE_W'(size); reqNeedsResp = needs; reqHdrDelay = '0; reqPayDelay = '0;
  endtask

  initial begin : main
    int n;
    // phase A: latency 3, variance 5, cost 2
    doReset(3, 5, 2);
    randomTraffic(600, 70);
    drain();
    // R2: size 3 at cost 2 -> six busy cycles
    sendOne(2'b10, 5, 32'hA5A5_0001, 3, 0);
    tick(); quiet();
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy) n++;
      tick();
    end
    chk("R2", "busy window length", n, 6);
    // R4: hold a request during a busy window, expect one retry strobe
    sendOne(2'b10, 6, 32'h0000_00AA, 2, 0);
    tick();
    sendOne(2'b01, 6, 0, 0, 0);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (retryStrobe) n++;
      if (reqReady) quiet();
    end
    chk("R4", "retry strobe count", n, 1);
    // R1: illegal command while idle
    tick();
    sendOne(2'b11, 7, 32'hDEAD, 2, 1);
    tick(); quiet();
    chk("R1", "cmdErr after illegal", cmdErr, 1);
    chk("R1", "no busy after illegal", busy, 0);
    tick();
    chk("R1", "cmdErr single cycle", cmdErr, 0);
    chk("R1", "no response for illegal", respValid, 0);

    // phase B: all zero configuration
    doReset(0, 0, 0);
    randomTraffic(400, 80);
    drain();
    // R7: posted write leaves nothing behind
    sendOne(2'b10, 9, 32'hC0FF_EE11, 3, 0);
    tick(); quiet();
    chk("R7", "idle after posted write", idle, 1);
    // R6: read back the word just written, zero latency
    sendOne(2'b01, 9, 0, 1, 1);
    tick(); quiet();
    chk("R6", "read response valid", respValid, 1);
    chk("R6", "read returns written word", respData, 32'hC0FF_EE11);
    tick();
    // R11: cost changed after reset has no effect
    cfgByteCost = 4'd7; cfgLatency = 8'd40;
    sendOne(2'b01, 9, 0, 3, 0);
    tick(); quiet();
    chk("R11", "late cost change ignored", busy, 0);
    randomTraffic(200, 80);
    drain();

    // phase C: long latency, heavy jitter, back-pressure to fill the buffer
    doReset(20, 15, 3);
    randomTraffic(500, 15);
    randomTraffic(300, 60);
    drain();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule